// File: doc/BRIEF.md
# Remappable Interrupt Channel Prioritizer

This block takes up to 128 level-sensitive interrupt request lines and routes them onto 128 prioritized channels. Every channel carries a programmable selector naming the request line that feeds it, so one request can sit on several channels at once. Each channel also has an enable bit and a group bit. The group bit places it in either the fast group or the normal group. For each group, the block reports the lowest-numbered channel that is enabled and whose selected request is high.

Software configures the block through a word-addressed register port. A request's effective priority can be changed at run time without touching the map. Map the request onto a high-priority channel and a low-priority channel, then enable or disable the high-priority copy. The two winner outputs are plain registered status, not a stream. They carry no handshake and no back-pressure: a consumer reads them whenever it wants, and they follow the request lines one clock later.

Top module: `chprio_top`

## Requirements
- R1: After reset, every channel n selects request line n. Map word w holds channels 4w..4w+3, and channel 4w+k sits in bits [8k+6:8k]. Map words are at addresses 0 to 31.
- R2: Channels 0 and 1 are tied to request lines 0 and 1. Writes to their fields have no effect, and the fields read back 0 and 1.
- R3: Channel 127 ignores writes to its field and always selects request line 127.
- R4: A write to a map word updates the fields of all other channels in that word. Each field takes the low 7 bits of its byte, and bit 7 of each byte is dropped. Read data bit 7 of each byte is 0.
- R5: All enables reset to 0. A write to set bank word b (address 32+b) sets enable 32b+i for each 1 in data bit i. A write to clear bank word b (address 36+b) clears those enables. Data bits that are 0 change nothing. A read of either bank returns the current enables.
- R6: A channel is pending when its enable is 1 and its selected request line is high. A request selected by several channels makes each of them pending independently, and a disabled channel is never pending.
- R7: Within each group, the lowest-numbered pending channel wins.
- R8: Type bank word b (address 40+b) holds one group bit per channel: 1 puts the channel in the fast group, 0 in the normal group. All group bits reset to 0.
- R9: Each group output is a 7-bit channel number plus a valid bit, registered one clock after the request and configuration state it reflects. With nothing pending in a group, valid is 0 and the channel number is 0.
- R10: Suppose request 2 drives channels 2 and 4 and request 3 drives channel 3. With channel 2 enabled, request 2 beats request 3. With channel 2 disabled, request 3 beats request 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 128 | Interrupt request lines, level-sensitive |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 6 | Register word address |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data for cfg_addr_i, combinational |
| fast_valid_o | output | 1 | Fast group has a pending channel |
| fast_chan_o | output | 7 | Winning fast channel, 0 when idle |
| norm_valid_o | output | 1 | Normal group has a pending channel |
| norm_chan_o | output | 7 | Winning normal channel, 0 when idle |

## Verification
The bench writes junk into the words holding channels 0, 1 and 127. A design that forgot the tie-offs would read back the junk, or would route channel 127 to a foreign request. It remaps channel 4 onto request 2 and toggles channel 2's enable. A design that resolved priority per request rather than per channel, or that let one request claim only one channel, would report the wrong winner in that swap. It also sets and clears enables with mixed zero and one data bits, and it splits two pending channels across the groups. This exposes set and clear banks that overwrite instead of merging, and group masks that are inverted. It samples the outputs both just before and just after the capturing edge, to catch an output that is one cycle early or late.

// File: rtl/chprio_pkg.sv
package chprio_pkg;
  localparam int NUM_CH      = 128;
  localparam int SEL_W       = $clog2(NUM_CH);
  localparam int DATA_W      = 32;
  localparam int BYTE_W      = 8;
  localparam int FLD_PER_WD  = DATA_W / BYTE_W;
  localparam int MAP_WORDS   = NUM_CH / FLD_PER_WD;
  localparam int BANK_WORDS  = NUM_CH / DATA_W;
  localparam int SET_BASE    = MAP_WORDS;
  localparam int CLR_BASE    = SET_BASE + BANK_WORDS;
  localparam int TYPE_BASE   = CLR_BASE + BANK_WORDS;
  localparam int ADDR_W      = $clog2(TYPE_BASE + BANK_WORDS);
  localparam int NUM_GRP     = 2;
  localparam int GRP_NORM    = 0;
  localparam int GRP_FAST    = 1;

  typedef logic [SEL_W-1:0] sel_t;
endpackage

// File: rtl/chprio_map_regs.sv
module chprio_map_regs
  import chprio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output sel_t              map_o [NUM_CH]
);
  sel_t map_q [NUM_CH];

  // one selector register per channel; tied channels never take a write
  for (genvar c = 0; c < NUM_CH; c++) begin : g_fld
    localparam bit TIED = (c < 2) || (c == NUM_CH - 1);
    localparam int WORD = c / FLD_PER_WD;
    localparam int LANE = c % FLD_PER_WD;
    if (TIED) begin : g_tied
      always_ff @(posedge clk_i) begin
        map_q[c] <= SEL_W'(c);
      end
    end else begin : g_prog
      always_ff @(posedge clk_i) begin
        if (!rst_ni)
          map_q[c] <= SEL_W'(c);
        else if (wr_en_i && (addr_i == ADDR_W'(WORD)))
          map_q[c] <= wdata_i[LANE*BYTE_W +: SEL_W];
      end
    end
    assign map_o[c] = map_q[c];
  end

  always_comb begin
    rdata_o = '0;
    if (int'(addr_i) < MAP_WORDS) begin
      for (int k = 0; k < FLD_PER_WD; k++) begin
        rdata_o[k*BYTE_W +: SEL_W] = map_q[SEL_W'(int'(addr_i) * FLD_PER_WD + k)];
      end
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  // R2: a write to the word holding channels 0 and 1 leaves them tied
  assert_tied_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == '0) |=> (map_q[0] == SEL_W'(0) && map_q[1] == SEL_W'(1)));

  // R3: channel 127 keeps its own request after a write to its word
  assert_tied_top_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(MAP_WORDS - 1)) |=> (map_q[NUM_CH-1] == SEL_W'(NUM_CH - 1)));
endmodule

// File: rtl/chprio_ctrl_regs.sv
module chprio_ctrl_regs
  import chprio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] type_o
);
  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] type_q;

  for (genvar b = 0; b < BANK_WORDS; b++) begin : g_bank
    logic set_hit, clr_hit, typ_hit;
    assign set_hit = wr_en_i && (addr_i == ADDR_W'(SET_BASE + b));
    assign clr_hit = wr_en_i && (addr_i == ADDR_W'(CLR_BASE + b));
    assign typ_hit = wr_en_i && (addr_i == ADDR_W'(TYPE_BASE + b));

    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        en_q[b*DATA_W +: DATA_W]   <= '0;
        type_q[b*DATA_W +: DATA_W] <= '0;
      end else begin
        if (set_hit)
          en_q[b*DATA_W +: DATA_W] <= en_q[b*DATA_W +: DATA_W] | wdata_i;
        else if (clr_hit)
          en_q[b*DATA_W +: DATA_W] <= en_q[b*DATA_W +: DATA_W] & ~wdata_i;
        if (typ_hit)
          type_q[b*DATA_W +: DATA_W] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < BANK_WORDS; b++) begin
      if (addr_i == ADDR_W'(SET_BASE + b) || addr_i == ADDR_W'(CLR_BASE + b))
        rdata_o = en_q[b*DATA_W +: DATA_W];
      else if (addr_i == ADDR_W'(TYPE_BASE + b))
        rdata_o = type_q[b*DATA_W +: DATA_W];
    end
  end

  assign en_o   = en_q;
  assign type_o = type_q;

  // R5: set bank with bit 0 raises enable 0
  assert_set_raises_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(SET_BASE) && wdata_i[0]) |=> en_q[0]);
  // R5: clear bank with bit 0 drops enable 0
  assert_clr_drops_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(CLR_BASE) && wdata_i[0]) |=> !en_q[0]);
  // R5: a zero data bit leaves the enable alone
  assert_zero_keeps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (addr_i == ADDR_W'(SET_BASE) || addr_i == ADDR_W'(CLR_BASE)) && !wdata_i[0])
    |=> $stable(en_q[0]));
endmodule

// File: rtl/chprio_pick.sv
module chprio_pick
  import chprio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] pend_i,
  output sel_t              chan_o,
  output logic              valid_o
);
  sel_t win;
  logic hit;

  // scan from the top down so the lowest index is assigned last
  always_comb begin
    win = '0;
    hit = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        win = SEL_W'(i);
        hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      chan_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      chan_o  <= win;
      valid_o <= hit;
    end
  end

  // checker state: the pending vector the outputs should reflect
  logic [NUM_CH-1:0] chk_pend_q;
  logic [NUM_CH-1:0] chk_below;
  always_ff @(posedge clk_i) begin
    if (!rst_ni) chk_pend_q <= '0;
    else         chk_pend_q <= pend_i;
  end
  assign chk_below = (NUM_CH'(1) << chan_o) - NUM_CH'(1);

  assert_lowest_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (chk_pend_q[chan_o] && ((chk_pend_q & chk_below) == '0)));
  assert_idle_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (chan_o == '0 && chk_pend_q == '0));
endmodule

// File: rtl/chprio_top.sv
module chprio_top
  import chprio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] req_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  output logic              fast_valid_o,
  output logic [SEL_W-1:0]  fast_chan_o,
  output logic              norm_valid_o,
  output logic [SEL_W-1:0]  norm_chan_o
);
  sel_t              map_w [NUM_CH];
  logic [NUM_CH-1:0] en_w, type_w, pend_w;
  logic [DATA_W-1:0] map_rdata, ctrl_rdata;

  chprio_map_regs u_map (
    .clk_i, .rst_ni,
    .wr_en_i (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (map_rdata),
    .map_o   (map_w)
  );

  chprio_ctrl_regs u_ctrl (
    .clk_i, .rst_ni,
    .wr_en_i (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (ctrl_rdata),
    .en_o    (en_w),
    .type_o  (type_w)
  );

  assign cfg_rdata_o = map_rdata | ctrl_rdata;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pend
    assign pend_w[c] = en_w[c] & req_i[map_w[c]];
  end

  logic [NUM_CH-1:0] grp_pend  [NUM_GRP];
  sel_t              grp_chan  [NUM_GRP];
  logic              grp_valid [NUM_GRP];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    if (g == GRP_FAST) begin : g_fast
      assign grp_pend[g] = pend_w & type_w;
    end else begin : g_norm
      assign grp_pend[g] = pend_w & ~type_w;
    end
    chprio_pick u_pick (
      .clk_i, .rst_ni,
      .pend_i  (grp_pend[g]),
      .chan_o  (grp_chan[g]),
      .valid_o (grp_valid[g])
    );
  end

  assign fast_valid_o = grp_valid[GRP_FAST];
  assign fast_chan_o  = grp_chan[GRP_FAST];
  assign norm_valid_o = grp_valid[GRP_NORM];
  assign norm_chan_o  = grp_chan[GRP_NORM];

  // checker state for group membership and enables seen by the outputs
  logic [NUM_CH-1:0] chk_type_q, chk_en_q;
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      chk_type_q <= '0;
      chk_en_q   <= '0;
    end else begin
      chk_type_q <= type_w;
      chk_en_q   <= en_w;
    end
  end

  assert_fast_member_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_valid_o |-> chk_type_q[fast_chan_o]);
  assert_norm_member_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    norm_valid_o |-> !chk_type_q[norm_chan_o]);
  assert_winner_enabled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_valid_o |-> chk_en_q[fast_chan_o]) and (norm_valid_o |-> chk_en_q[norm_chan_o]));
endmodule

// File: tb/chprio_top_tb.sv
module chprio_top_tb;
  import chprio_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NUM_CH-1:0] req = '0;
  logic              we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              fv, nv;
  logic [SEL_W-1:0]  fc, nc;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  chprio_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
    .fast_valid_o(fv), .fast_chan_o(fc), .norm_valid_o(nv), .norm_chan_o(nc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // packs {fast_valid, fast_chan, norm_valid, norm_chan}
  task automatic chk_out(input string tag, input logic f_v, input int f_c,
                         input logic n_v, input int n_c);
    chk(tag, {16'h0, fv, fc, nv, nc}, {16'h0, f_v, 7'(f_c), n_v, 7'(n_c)});
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    addr = ADDR_W'(a);
    #1 d = rdata;
  endtask

  task automatic drive_req(input logic [NUM_CH-1:0] v);
    @(negedge clk);
    req = v;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [NUM_CH-1:0] bits(input int a, input int b = -1, input int c = -1);
    logic [NUM_CH-1:0] v = '0;
    v[a] = 1'b1;
    if (b >= 0) v[b] = 1'b1;
    if (c >= 0) v[c] = 1'b1;
    return v;
  endfunction

  task automatic cleanup();
    for (int b = 0; b < BANK_WORDS; b++) begin
      wr(CLR_BASE + b, 32'hFFFF_FFFF);
      wr(TYPE_BASE + b, 32'h0);
    end
    drive_req('0);
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk_out("R9 idle after reset", 1'b0, 0, 1'b0, 0);
    rd(0, d);  chk("R1 map word 0 identity", d, 32'h0302_0100);
    rd(1, d);  chk("R1 map word 1 identity", d, 32'h0706_0504);
    rd(31, d); chk("R1 map word 31 identity", d, 32'h7F7E_7D7C);
    rd(SET_BASE, d);      chk("R5 enables reset to 0", d, 32'h0);
    rd(TYPE_BASE + 3, d); chk("R8 group bits reset to 0", d, 32'h0);
  endtask

  task automatic t_tied();
    logic [31:0] d;
    wr(0, 32'h0586_0708);
    rd(0, d); chk("R2 R4 tied low channels, ch2 ch3 written", d, 32'h0506_0100);
    wr(0, 32'h0302_0100);
    wr(31, 32'h1122_3344);
    rd(31, d); chk("R3 R4 channel 127 kept", d, 32'h7F22_3344);
    wr(31, 32'h7F7E_7D7C);
    wr(SET_BASE + 3, 32'h8000_0000);
    drive_req(bits(127));
    chk_out("R3 channel 127 follows request 127", 1'b0, 0, 1'b1, 127);
    cleanup();
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(SET_BASE, 32'h0000_000F);
    rd(SET_BASE, d); chk("R5 set bank readback", d, 32'h0000_000F);
    rd(CLR_BASE, d); chk("R5 clear bank reads enables", d, 32'h0000_000F);
    wr(CLR_BASE, 32'h0000_0005);
    rd(SET_BASE, d); chk("R5 clear only ones", d, 32'h0000_000A);
    wr(SET_BASE, 32'h0);
    rd(CLR_BASE, d); chk("R5 zero write no change", d, 32'h0000_000A);
    wr(SET_BASE + 2, 32'h0000_0100);
    rd(CLR_BASE + 2, d); chk("R5 bank 2 set", d, 32'h0000_0100);
    cleanup();
  endtask

  task automatic t_latency();
    wr(SET_BASE, 32'h0000_0020);
    @(negedge clk);
    req = bits(5);
    #1 chk_out("R9 not yet visible before edge", 1'b0, 0, 1'b0, 0);
    @(posedge clk); #1;
    chk_out("R9 visible after one edge", 1'b0, 0, 1'b1, 5);
    drive_req(bits(6));
    chk_out("R6 disabled channel not pending", 1'b0, 0, 1'b0, 0);
    cleanup();
  endtask

  task automatic t_priority();
    wr(SET_BASE, 32'h0010_0400);
    wr(SET_BASE + 2, 32'h0000_0040);
    drive_req(bits(10, 20, 70));
    chk_out("R7 lowest of three", 1'b0, 0, 1'b1, 10);
    drive_req(bits(20, 70));
    chk_out("R7 next lowest", 1'b0, 0, 1'b1, 20);
    drive_req(bits(70));
    chk_out("R7 upper bank only", 1'b0, 0, 1'b1, 70);
    cleanup();
  endtask

  task automatic t_groups();
    wr(SET_BASE, 32'h0010_0400);
    wr(TYPE_BASE, 32'h0010_0000);
    drive_req(bits(10, 20));
    chk_out("R8 split fast 20 normal 10", 1'b1, 20, 1'b1, 10);
    drive_req(bits(20));
    chk_out("R8 fast only", 1'b1, 20, 1'b0, 0);
    cleanup();
  endtask

  task automatic t_shared();
    wr(1, 32'h0706_0502);
    wr(SET_BASE, 32'h0000_001C);
    drive_req(bits(2, 3));
    chk_out("R10 channel 2 enabled, request 2 first", 1'b0, 0, 1'b1, 2);
    wr(CLR_BASE, 32'h0000_0004);
    drive_req(bits(2, 3));
    chk_out("R10 channel 2 disabled, request 3 first", 1'b0, 0, 1'b1, 3);
    drive_req(bits(2));
    chk_out("R6 request 2 via channel 4", 1'b0, 0, 1'b1, 4);
    drive_req(bits(4));
    chk_out("R4 request 4 no longer on channel 4", 1'b0, 0, 1'b0, 0);
    wr(1, 32'h0706_0504);
    cleanup();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_tied();
    t_enable();
    t_latency();
    t_priority();
    t_groups();
    t_shared();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule